// File: doc/BRIEF.md
# Two-wire serial EEPROM slave engine

This block is the bus-facing half of a byte-addressed nonvolatile memory that sits on a two-wire open-drain bus. It runs on a fast system clock and oversamples the clock line and data line. It finds start and stop conditions and takes in the device address byte, which it compares against a fixed code and two chip-select pins. It then either collects a two-byte word address and write data, or returns read data from an internal address pointer. It never drives the data line high. It only asserts a pull-low enable, which the pad turns into an open-drain driver.

The memory array is outside the block and is reached through a request stream. `mem_valid_o` offers a request made of a write flag, a 15-bit address and write data. The request is held, with the payload unchanged, until `mem_ready_i` is high in the same cycle. For a read, the array returns data on `mem_rdata_i` in the cycle after the handshake.

The memory must accept a request and return its data within a few system clocks. Read data is needed on the line at the next falling clock edge, so a memory that is slower than that delivers stale bits.

After a stop that ends a write with at least one data byte, the block runs a self-timed write window of `TWR_CYCLES` clocks. During that window it refuses to acknowledge its own address. A host can therefore poll until an acknowledge comes back.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A start condition (data line falls while the clock line is high) in any state, including in the middle of a byte, restarts device-address reception. A stop condition (data line rises while the clock line is high) returns the block to idle.
- R2: The device byte is matched when bits [7:4] are 1010, bit 3 is 0 and bits [2:1] equal `chip_sel_i`. On a match the block acknowledges by asserting `sda_pull_o` through the ninth clock-high phase. On a mismatch it does not acknowledge, makes no memory request and keeps the line released until the next start.
- R3: Bit 0 of the device byte selects the direction: 1 is a read and 0 is a write.
- R4: In a write, the two bytes after the device byte form the word address, high byte first. Bit 7 of the high byte is ignored. Every byte is acknowledged, and each data byte produces one memory write request at the current pointer.
- R5: After each written byte only the low 6 pointer bits advance, so writing past the end of a 64-byte page continues at the start of the same page.
- R6: A stop that ends a write carrying at least one data byte raises `wr_busy_o` for `TWR_CYCLES` clocks. While it is high, a matching device byte is not acknowledged and `sda_pull_o` stays low. Acknowledges resume once it falls.
- R7: Each read data bit is presented after a falling clock edge, with `sda_pull_o` equal to the inverse of the bit, MSB first. `sda_pull_o` changes only while the clock line is low.
- R8: A read with no preceding word address starts at the last accessed location plus one.
- R9: During a read, a host acknowledge (data line low in the ninth clock) continues with the next address. The pointer wraps from 0x7FFF to 0x0000. A host no-acknowledge ends the read with no further memory request.
- R10: A memory request keeps `mem_write_o`, `mem_addr_o` and `mem_wdata_o` stable while `mem_valid_o` is high and `mem_ready_i` is low.
- R11: After reset, `sda_pull_o`, `mem_valid_o` and `wr_busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | Pull-low enable for the open-drain data driver |
| chip_sel_i | input | 2 | Strapped chip-select value compared with device byte bits [2:1] |
| wr_busy_o | output | 1 | Self-timed write window active |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory request accepted |
| mem_write_o | output | 1 | Request is a write (1) or read (0) |
| mem_addr_o | output | 15 | Request byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a read handshake |

## Verification
The hardest situation to reach is a refused acknowledge during the self-timed write window. It only exists for a bounded time after a stop that followed real data, and the number of refusals depends on how that window lines up with bus timing. The stimulus writes a short burst and then, without pausing, polls with device bytes. It records each refusal and requires at least one refusal and a bounded total before an acknowledge arrives. Pointer wrap at the page edge and at the top of the array is reached by loading word addresses just below those boundaries. A dummy write followed by a repeated start exercises the mid-transfer restart.

// File: rtl/twi_eeprom_pkg.sv
`timescale 1ns/1ps
package twi_eeprom_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} twi_state_e;
  typedef enum logic [1:0] {K_DEV, K_WAH, K_WAL, K_DATA} rx_kind_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  function automatic rx_kind_e next_kind(rx_kind_e k);
    case (k)
      K_DEV:   return K_WAH;
      K_WAH:   return K_WAL;
      default: return K_DATA;
    endcase
  endfunction
endpackage

// File: rtl/twi_line_sync.sv
`timescale 1ns/1ps
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_chain, sda_chain;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[STAGES-2:0], sda_i};
      scl_q     <= scl_s;
      sda_q     <= sda_s;
    end
  end

  assign scl_s      = scl_chain[STAGES-1];
  assign sda_s      = sda_chain[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_addr_ptr.sv
`timescale 1ns/1ps
module twi_addr_ptr #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [7:0]        byte_i,
  input  logic              step_page_i,
  input  logic              step_seq_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ld_hi_i) begin
      ptr_q <= {byte_i[HI_W-1:0], ptr_q[7:0]};
    end else if (ld_lo_i) begin
      ptr_q <= {ptr_q[ADDR_W-1:8], byte_i};
    end else if (step_page_i) begin
      ptr_q <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
    end else if (step_seq_i) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/twi_wr_timer.sv
`timescale 1ns/1ps
module twi_wr_timer #(
  parameter int TWR_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  output logic busy_o
);
  localparam int CW = $clog2(TWR_CYCLES + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (kick_i) begin
      left_q <= CW'(TWR_CYCLES);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign busy_o = (left_q != '0);
endmodule

// File: rtl/twi_proto_fsm.sv
`timescale 1ns/1ps
module twi_proto_fsm
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        chip_sel_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic              sda_pull_o,
  output logic              ld_hi_o,
  output logic              ld_lo_o,
  output logic              step_page_o,
  output logic              step_seq_o,
  output logic [7:0]        rx_byte_o,
  output logic              commit_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  twi_state_e        state_q;
  rx_kind_e          kind_q;
  logic [3:0]        bit_q;
  logic [7:0]        shreg_q, txb_q;
  logic              pull_q, rd_mode_q, wrote_q, mack_q, rd_pend_q;
  logic              ld_hi_q, ld_lo_q, step_page_q, step_seq_q, commit_q;
  logic              mem_valid_q, mem_write_q;
  logic [ADDR_W-1:0] mem_addr_q;
  logic [7:0]        mem_wdata_q;
  logic              dev_hit;

  assign dev_hit = (shreg_q[7:1] == {DEV_CODE, 1'b0, chip_sel_i}) && !busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      kind_q      <= K_DEV;
      bit_q       <= '0;
      shreg_q     <= '0;
      txb_q       <= '0;
      pull_q      <= 1'b0;
      rd_mode_q   <= 1'b0;
      wrote_q     <= 1'b0;
      mack_q      <= 1'b0;
      rd_pend_q   <= 1'b0;
      ld_hi_q     <= 1'b0;
      ld_lo_q     <= 1'b0;
      step_page_q <= 1'b0;
      step_seq_q  <= 1'b0;
      commit_q    <= 1'b0;
      mem_valid_q <= 1'b0;
      mem_write_q <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
    end else begin
      ld_hi_q     <= 1'b0;
      ld_lo_q     <= 1'b0;
      step_page_q <= 1'b0;
      step_seq_q  <= 1'b0;
      commit_q    <= 1'b0;
      rd_pend_q   <= mem_valid_q && mem_ready_i && !mem_write_q;
      if (rd_pend_q) txb_q <= mem_rdata_i;
      if (mem_valid_q && mem_ready_i) mem_valid_q <= 1'b0;

      if (start_i) begin
        state_q <= ST_RX;
        kind_q  <= K_DEV;
        bit_q   <= '0;
        pull_q  <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
        if (wrote_q) begin
          commit_q <= 1'b1;
          wrote_q  <= 1'b0;
        end
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise_i && !bit_q[3]) begin
              shreg_q <= {shreg_q[6:0], sda_i};
              bit_q   <= bit_q + 1'b1;
            end else if (scl_fall_i && bit_q[3]) begin
              bit_q <= '0;
              case (kind_q)
                K_DEV: begin
                  if (dev_hit) begin
                    pull_q    <= 1'b1;
                    state_q   <= ST_ACK;
                    rd_mode_q <= shreg_q[0];
                    if (shreg_q[0]) begin
                      mem_valid_q <= 1'b1;
                      mem_write_q <= 1'b0;
                      mem_addr_q  <= ptr_i;
                      step_seq_q  <= 1'b1;
                    end
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                K_WAH: begin
                  ld_hi_q <= 1'b1;
                  pull_q  <= 1'b1;
                  state_q <= ST_ACK;
                end
                K_WAL: begin
                  ld_lo_q <= 1'b1;
                  pull_q  <= 1'b1;
                  state_q <= ST_ACK;
                end
                default: begin
                  mem_valid_q <= 1'b1;
                  mem_write_q <= 1'b1;
                  mem_addr_q  <= ptr_i;
                  mem_wdata_q <= shreg_q;
                  step_page_q <= 1'b1;
                  wrote_q     <= 1'b1;
                  pull_q      <= 1'b1;
                  state_q     <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              bit_q <= '0;
              if (rd_mode_q) begin
                state_q <= ST_TX;
                pull_q  <= ~txb_q[7];
              end else begin
                state_q <= ST_RX;
                pull_q  <= 1'b0;
                kind_q  <= next_kind(kind_q);
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (bit_q == 4'd7) begin
                pull_q  <= 1'b0;
                state_q <= ST_MACK;
              end else begin
                pull_q <= ~txb_q[6];
                txb_q  <= {txb_q[6:0], 1'b0};
                bit_q  <= bit_q + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
              if (!sda_i) begin
                mem_valid_q <= 1'b1;
                mem_write_q <= 1'b0;
                mem_addr_q  <= ptr_i;
                step_seq_q  <= 1'b1;
              end
            end else if (scl_fall_i) begin
              bit_q <= '0;
              if (mack_q) begin
                state_q <= ST_TX;
                pull_q  <= ~txb_q[7];
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o  = pull_q;
  assign ld_hi_o     = ld_hi_q;
  assign ld_lo_o     = ld_lo_q;
  assign step_page_o = step_page_q;
  assign step_seq_o  = step_seq_q;
  assign rx_byte_o   = shreg_q;
  assign commit_o    = commit_q;
  assign mem_valid_o = mem_valid_q;
  assign mem_write_o = mem_write_q;
  assign mem_addr_o  = mem_addr_q;
  assign mem_wdata_o = mem_wdata_q;
endmodule

// File: rtl/twi_eeprom_slave.sv
`timescale 1ns/1ps
module twi_eeprom_slave #(
  parameter int ADDR_W      = 15,
  parameter int PAGE_W      = 6,
  parameter int TWR_CYCLES  = 10000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [1:0]        chip_sel_i,
  output logic              wr_busy_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              ld_hi, ld_lo, step_page, step_seq, commit, busy;
  logic [7:0]        rx_byte;
  logic [ADDR_W-1:0] ptr;

  twi_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk, .rst_n, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  twi_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_ptr (
    .clk, .rst_n, .ld_hi_i(ld_hi), .ld_lo_i(ld_lo), .byte_i(rx_byte),
    .step_page_i(step_page), .step_seq_i(step_seq), .ptr_o(ptr)
  );

  twi_wr_timer #(.TWR_CYCLES(TWR_CYCLES)) i_timer (
    .clk, .rst_n, .kick_i(commit), .busy_o(busy)
  );

  twi_proto_fsm #(.ADDR_W(ADDR_W)) i_fsm (
    .clk, .rst_n, .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .start_i(start_det), .stop_i(stop_det), .chip_sel_i, .busy_i(busy), .ptr_i(ptr),
    .sda_pull_o, .ld_hi_o(ld_hi), .ld_lo_o(ld_lo), .step_page_o(step_page),
    .step_seq_o(step_seq), .rx_byte_o(rx_byte), .commit_o(commit),
    .mem_valid_o, .mem_ready_i, .mem_write_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i
  );

  assign wr_busy_o = busy;
endmodule

// File: rtl/twi_eeprom_slave_chk.sv
`timescale 1ns/1ps
module twi_eeprom_slave_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_pull_o,
  input logic              wr_busy_o,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic              mem_write_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [7:0]        mem_wdata_o
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)
                                    && $stable(mem_write_o) && $stable(mem_wdata_o));

  p_quiet_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy_o |-> !sda_pull_o);

  p_busy_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_busy_o) |-> scl_i);

  p_pull_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);
endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .wr_busy_o(wr_busy_o), .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
  .mem_write_o(mem_write_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
);

// File: tb/test_twi_eeprom_slave.sv
`timescale 1ns/1ps
module test_twi_eeprom_slave;
  localparam int H   = 8;
  localparam int TWR = 600;
  localparam logic [7:0] DEV_W = 8'hA4;
  localparam logic [7:0] DEV_R = 8'hA5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        host_pull = 1'b0;
  logic        sda_pull_o, wr_busy_o, mem_valid_o, mem_write_o;
  logic        mem_ready = 1'b0;
  logic        rdy_tog = 1'b0;
  logic [14:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata = 8'h00;
  logic        sda_line;

  assign sda_line = !(host_pull || sda_pull_o);

  twi_eeprom_slave #(.TWR_CYCLES(TWR)) i_twi_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull_o),
    .chip_sel_i(2'b10), .wr_busy_o(wr_busy_o), .mem_valid_o(mem_valid_o),
    .mem_ready_i(mem_ready), .mem_write_o(mem_write_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural memory behind the request stream, and the reference model
  logic [7:0] store [int];
  logic [7:0] ref_mem [int];
  int ref_ptr = 0;
  int wr_addr_q[$];
  int wr_data_q[$];
  int rd_reqs = 0;

  function automatic logic [7:0] seed_val(int a);
    return 8'(a) ^ 8'(a >> 7) ^ 8'h3C;
  endfunction
  function automatic logic [7:0] ref_rd(int a);
    return ref_mem.exists(a) ? ref_mem[a] : seed_val(a);
  endfunction

  always @(posedge clk) begin
    rdy_tog   <= ~rdy_tog;
    mem_ready <= rdy_tog;
    if (rst_n && mem_valid_o && mem_ready) begin
      if (mem_write_o) begin
        store[int'(mem_addr_o)] = mem_wdata_o;
        wr_addr_q.push_back(int'(mem_addr_o));
        wr_data_q.push_back(int'(mem_wdata_o));
      end else begin
        mem_rdata <= store.exists(int'(mem_addr_o)) ? store[int'(mem_addr_o)] : seed_val(int'(mem_addr_o));
        rd_reqs++;
      end
    end
  end

  // per-clock comparison of the expected pull during clock-high phases
  bit    exp_on = 0;
  bit    exp_pull = 0;
  string exp_req = "R7";
  always @(negedge clk) if (exp_on) chk(exp_req, sda_pull_o, exp_pull);

  // R10 request stability observed at the ports
  logic        pv = 0, pr = 0, pw = 0;
  logic [14:0] pa = '0;
  logic [7:0]  pd = '0;
  always @(negedge clk) begin
    if (rst_n && pv && !pr)
      chk("R10", {mem_valid_o, mem_write_o, mem_addr_o, mem_wdata_o}, {1'b1, pw, pa, pd});
    pv = mem_valid_o; pr = mem_ready; pw = mem_write_o; pa = mem_addr_o; pd = mem_wdata_o;
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic high_window(bit e, string req);
    @(posedge clk); @(posedge clk);
    exp_req = req; exp_pull = e; exp_on = 1;
    repeat (H - 3) @(posedge clk);
    exp_on = 0;
    @(negedge clk);
  endtask

  task automatic host_bit(bit b, string req);
    host_pull = !b; wt(H);
    scl = 1'b1; high_window(1'b0, req);
    scl = 1'b0; wt(1);
  endtask

  task automatic dev_bit(bit e, string req);
    host_pull = 1'b0; wt(H);
    scl = 1'b1; high_window(e, req);
    scl = 1'b0; wt(1);
  endtask

  task automatic sample_bit(output bit pulled);
    host_pull = 1'b0; wt(H);
    scl = 1'b1; wt(H / 2);
    pulled = sda_pull_o; wt(H / 2);
    scl = 1'b0; wt(1);
  endtask

  task automatic bus_start();
    host_pull = 1'b0; wt(H);
    scl = 1'b1; wt(H);
    host_pull = 1'b1; wt(H);
    scl = 1'b0; wt(1);
  endtask

  task automatic bus_stop();
    host_pull = 1'b1; wt(H);
    scl = 1'b1; wt(H);
    host_pull = 1'b0; wt(H);
  endtask

  task automatic send_byte(logic [7:0] b, bit ack, string req);
    for (int i = 7; i >= 0; i--) host_bit(b[i], req);
    dev_bit(ack, req);
  endtask

  task automatic recv_byte(logic [7:0] e, bit mack, string req);
    for (int i = 7; i >= 0; i--) dev_bit(!e[i], req);
    host_bit(!mack, req);
  endtask

  task automatic write_burst(logic [7:0] hi, logic [7:0] lo, int n, int base_val);
    int p;
    bus_start();
    send_byte(DEV_W, 1'b1, "R3");
    send_byte(hi, 1'b1, "R4");
    send_byte(lo, 1'b1, "R4");
    p = {hi[6:0], lo};
    for (int i = 0; i < n; i++) begin
      send_byte(8'(base_val + i), 1'b1, "R4");
      ref_mem[p] = 8'(base_val + i);
      p = (p & 32'h7FC0) | ((p + 1) & 32'h3F);
    end
    ref_ptr = p;
    bus_stop();
  endtask

  task automatic poll_ready(output int polls);
    bit got;
    polls = 0;
    got = 0;
    while (!got && polls < 40) begin
      bus_start();
      for (int i = 7; i >= 0; i--) host_bit(DEV_W[i], "R6");
      sample_bit(got);
      if (!got) polls++;
      bus_stop();
    end
  endtask

  task automatic random_read(logic [7:0] hi, logic [7:0] lo, int n, string req);
    int p;
    bus_start();
    send_byte(DEV_W, 1'b1, "R1");
    send_byte(hi, 1'b1, "R1");
    send_byte(lo, 1'b1, "R1");
    bus_start();
    send_byte(DEV_R, 1'b1, "R3");
    p = {hi[6:0], lo};
    for (int i = 0; i < n; i++) begin
      recv_byte(ref_rd(p), i != n - 1, req);
      p = (p + 1) & 32'h7FFF;
    end
    ref_ptr = p;
    bus_stop();
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int polls, nw, nr;
    wt(5);
    chk("R11", {sda_pull_o, mem_valid_o, wr_busy_o}, 3'b000);
    rst_n = 1'b1;
    wt(5);
    chk("R11", {sda_pull_o, mem_valid_o, wr_busy_o}, 3'b000);

    // R2: wrong chip-select, then wrong fixed bit 3: no ack, bytes ignored
    nw = wr_addr_q.size(); nr = rd_reqs;
    bus_start();
    send_byte(8'hA2, 1'b0, "R2");
    send_byte(8'h00, 1'b0, "R2");
    send_byte(8'h55, 1'b0, "R2");
    bus_stop();
    bus_start();
    send_byte(8'hAC, 1'b0, "R2");
    bus_stop();
    chk("R2", wr_addr_q.size() + rd_reqs, nw + nr);

    // R4: write three bytes, top address bit ignored
    nw = wr_addr_q.size();
    write_burst(8'h81, 8'h23, 3, 8'h10);
    wt(6);
    chk("R6", wr_busy_o, 1'b1);
    chk("R4", wr_addr_q.size() - nw, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R4", wr_addr_q[nw + i], 32'h0123 + i);
      chk("R4", wr_data_q[nw + i], 32'h10 + i);
    end

    // R6: acknowledge polling
    poll_ready(polls);
    chk("R6", (polls >= 1) && (polls <= 8), 1'b1);
    chk("R6", wr_busy_o, 1'b0);

    // R8: current-address read continues after the last write
    nr = rd_reqs;
    bus_start();
    send_byte(DEV_R, 1'b1, "R3");
    recv_byte(ref_rd(ref_ptr), 1'b0, "R8");
    bus_stop();
    ref_ptr = (ref_ptr + 1) & 32'h7FFF;
    chk("R8", rd_reqs - nr, 1);

    // R5: page roll-over inside a 64-byte page
    nw = wr_addr_q.size();
    write_burst(8'h02, 8'hFE, 4, 8'hC0);
    chk("R5", wr_addr_q[nw + 0], 32'h02FE);
    chk("R5", wr_addr_q[nw + 1], 32'h02FF);
    chk("R5", wr_addr_q[nw + 2], 32'h02C0);
    chk("R5", wr_addr_q[nw + 3], 32'h02C1);
    poll_ready(polls);
    chk("R6", polls >= 1, 1'b1);

    // R1/R9: dummy write then repeated start, sequential read across a page
    nr = rd_reqs;
    random_read(8'h02, 8'hFF, 3, "R9");
    chk("R9", rd_reqs - nr, 3);
    chk("R1", wr_busy_o, 1'b0);

    // R9: wrap at the top of the array
    nr = rd_reqs;
    random_read(8'h7F, 8'hFE, 3, "R9");
    chk("R9", rd_reqs - nr, 3);

    // R8: current read after the wrap
    bus_start();
    send_byte(DEV_R, 1'b1, "R3");
    recv_byte(ref_rd(ref_ptr), 1'b0, "R8");
    bus_stop();

    // R1: start in the middle of a data byte aborts it; no write issued
    nw = wr_addr_q.size();
    bus_start();
    send_byte(DEV_W, 1'b1, "R1");
    send_byte(8'h00, 1'b1, "R1");
    send_byte(8'h40, 1'b1, "R1");
    host_bit(1'b1, "R1");
    host_bit(1'b0, "R1");
    bus_start();
    send_byte(DEV_R, 1'b1, "R1");
    recv_byte(ref_rd(32'h0040), 1'b0, "R1");
    bus_stop();
    chk("R1", wr_addr_q.size(), nw);
    wt(4);
    chk("R6", wr_busy_o, 1'b0);

    done = 1;
    summary();
    $finish;
  end
endmodule